// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block sits between a processor's interrupt-acknowledge request and a two-level tree of priority interrupt controllers. A secondary controller feeds its request output into input line 2 of the primary controller. Each controller contains its own priority resolver, and that resolver lives outside this block. This block sees only the resolvers' results: a "has winner" flag and a 3-bit line index per level, plus each controller's 5-bit vector base.

When an acknowledge request is accepted, the block samples both resolvers. It then pulses an acknowledge strobe, with a line index, to whichever controller or controllers own the winning interrupt. Finally it presents an 8-bit interrupt vector and a 4-bit global line number (0 to 15).

Each level handles an empty resolver with a spurious substitute on line 7:

- If the primary controller has no winner, the block returns a spurious primary vector.
- If the primary winner is the cascade line but the secondary controller has no winner, the block returns a spurious secondary vector.

In every cascaded case, the primary controller's line 2 is acknowledged only after the secondary controller has been handled.

Top module: `cascade_ack_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `m_ack_stb`, `s_ack_stb` and `vec_valid` are low.
- R2: If the primary has no winner when the request is accepted, neither strobe fires. The result cycle shows `vec` = {`m_base`, 3'd7} and `gline` = 7.
- R3: If the primary winner is a line L other than 2, `m_ack_stb` pulses with `m_ack_line` = L in the cycle after acceptance (the strobe cycle). In the next cycle (the result cycle), `vec` = {`m_base`, L} and `gline` = L.
- R4: If the primary winner is line 2 and the secondary has winner S, `s_ack_stb` pulses with `s_ack_line` = S in the strobe cycle. The result cycle shows `vec` = {`s_base`, S} and `gline` = 8 + S.
- R5: If the primary winner is line 2 and the secondary has no winner, `s_ack_stb` stays low. The result cycle shows `vec` = {`s_base`, 3'd7} and `gline` = 15.
- R6: In both cascaded cases, `m_ack_stb` pulses with `m_ack_line` = 2 in the result cycle, never in the strobe cycle.
- R7: A request is accepted when it arrives in an idle cycle or in a result cycle. A request arriving in the strobe cycle is ignored and produces no strobe and no extra result.
- R8: Resolver flags, lines and bases are sampled only in the accepting cycle. Later changes do not alter the strobes or the result of that acknowledge.
- R9: `vec_valid` is a one-cycle pulse. `m_ack_stb` and `s_ack_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_req | input | 1 | Processor acknowledge request |
| m_has_win | input | 1 | Primary resolver has a pending winner |
| m_win_line | input | 3 | Primary winning line |
| m_base | input | 5 | Primary vector base (vector bits 7:3) |
| s_has_win | input | 1 | Secondary resolver has a pending winner |
| s_win_line | input | 3 | Secondary winning line |
| s_base | input | 5 | Secondary vector base (vector bits 7:3) |
| m_ack_stb | output | 1 | Acknowledge pulse to the primary controller |
| m_ack_line | output | 3 | Line acknowledged on the primary |
| s_ack_stb | output | 1 | Acknowledge pulse to the secondary controller |
| s_ack_line | output | 3 | Line acknowledged on the secondary |
| vec_valid | output | 1 | Result cycle marker |
| vec | output | 8 | Interrupt vector |
| gline | output | 4 | Global line number |

## Verification
Two functions can land in the same cycle.

The first pair is the result cycle of one acknowledge and the acceptance of the next one. The bench provokes this with back-to-back requests. It judges the overlap by checking that the new strobe appears exactly one cycle after the old result, with the old vector still intact.

The second pair is the deferred primary line-2 strobe and the presentation of the cascaded vector, which share the result cycle. Cascade hits and cascade misses are forced with resolver inputs that change immediately after acceptance. A cycle-level model then compares every strobe, line, vector and global line number on every clock, including requests deliberately raised during strobe cycles.

// File: rtl/casack_pkg.sv
package casack_pkg;
    parameter int LINE_W    = 3;
    parameter int VEC_W     = 8;
    parameter int BASE_W    = VEC_W - LINE_W;
    parameter int GLN_W     = LINE_W + 1;
    parameter logic [LINE_W-1:0] CASC_LINE = LINE_W'(2);
    parameter logic [LINE_W-1:0] SPUR_LINE = {LINE_W{1'b1}};

    typedef enum logic [1:0] {
        K_SPUR_M    = 2'd0,
        K_DIRECT    = 2'd1,
        K_CASC_HIT  = 2'd2,
        K_CASC_MISS = 2'd3
    } ack_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_RESULT = 2'd2
    } phase_e;

    typedef struct packed {
        ack_kind_e          kind;
        logic [LINE_W-1:0]  m_line;
        logic [LINE_W-1:0]  s_line;
        logic [VEC_W-1:0]   vec;
        logic [GLN_W-1:0]   gline;
    } ack_plan_t;

    function automatic logic [VEC_W-1:0] form_vec(input logic [BASE_W-1:0] base,
                                                  input logic [LINE_W-1:0] line);
        return {base, line};
    endfunction

    function automatic logic [GLN_W-1:0] form_gline(input logic upper,
                                                    input logic [LINE_W-1:0] line);
        return {upper, line};
    endfunction
endpackage

// File: rtl/cas_resolve.sv
module cas_resolve
    import casack_pkg::*;
(
    input  logic              m_has_win,
    input  logic [LINE_W-1:0] m_win_line,
    input  logic [BASE_W-1:0] m_base,
    input  logic              s_has_win,
    input  logic [LINE_W-1:0] s_win_line,
    input  logic [BASE_W-1:0] s_base,
    output ack_plan_t         plan
);
    always_comb begin
        plan = '0;
        if (!m_has_win) begin
            plan.kind   = K_SPUR_M;
            plan.m_line = SPUR_LINE;
            plan.vec    = form_vec(m_base, SPUR_LINE);
            plan.gline  = form_gline(1'b0, SPUR_LINE);
        end else if (m_win_line != CASC_LINE) begin
            plan.kind   = K_DIRECT;
            plan.m_line = m_win_line;
            plan.vec    = form_vec(m_base, m_win_line);
            plan.gline  = form_gline(1'b0, m_win_line);
        end else if (s_has_win) begin
            plan.kind   = K_CASC_HIT;
            plan.m_line = CASC_LINE;
            plan.s_line = s_win_line;
            plan.vec    = form_vec(s_base, s_win_line);
            plan.gline  = form_gline(1'b1, s_win_line);
        end else begin
            plan.kind   = K_CASC_MISS;
            plan.m_line = CASC_LINE;
            plan.s_line = SPUR_LINE;
            plan.vec    = form_vec(s_base, SPUR_LINE);
            plan.gline  = form_gline(1'b1, SPUR_LINE);
        end
    end
endmodule

// File: rtl/cas_seq.sv
module cas_seq
    import casack_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ack_req,
    input  ack_plan_t plan_in,
    output phase_e    phase,
    output ack_plan_t plan_q
);
    logic accept;

    assign accept = ack_req && (phase != PH_STROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            plan_q <= '0;
        end else begin
            if (accept) begin
                phase  <= PH_STROBE;
                plan_q <= plan_in;
            end else if (phase == PH_STROBE) begin
                phase  <= PH_RESULT;
            end else begin
                phase  <= PH_IDLE;
            end
        end
    end
endmodule

// File: rtl/cas_drive.sv
module cas_drive
    import casack_pkg::*;
(
    input  phase_e            phase,
    input  ack_plan_t         plan_q,
    output logic              m_ack_stb,
    output logic [LINE_W-1:0] m_ack_line,
    output logic              s_ack_stb,
    output logic [LINE_W-1:0] s_ack_line,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec,
    output logic [GLN_W-1:0]  gline
);
    logic cascaded;

    assign cascaded = (plan_q.kind == K_CASC_HIT) || (plan_q.kind == K_CASC_MISS);

    always_comb begin
        m_ack_stb  = 1'b0;
        s_ack_stb  = 1'b0;
        vec_valid  = 1'b0;
        unique case (phase)
            PH_STROBE: begin
                m_ack_stb = (plan_q.kind == K_DIRECT);
                s_ack_stb = (plan_q.kind == K_CASC_HIT);
            end
            PH_RESULT: begin
                m_ack_stb = cascaded;
                vec_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign m_ack_line = plan_q.m_line;
    assign s_ack_line = plan_q.s_line;
    assign vec        = vec_valid ? plan_q.vec : '0;
    assign gline      = vec_valid ? plan_q.gline : '0;
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq
    import casack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_req,
    input  logic              m_has_win,
    input  logic [LINE_W-1:0] m_win_line,
    input  logic [BASE_W-1:0] m_base,
    input  logic              s_has_win,
    input  logic [LINE_W-1:0] s_win_line,
    input  logic [BASE_W-1:0] s_base,
    output logic              m_ack_stb,
    output logic [LINE_W-1:0] m_ack_line,
    output logic              s_ack_stb,
    output logic [LINE_W-1:0] s_ack_line,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec,
    output logic [GLN_W-1:0]  gline
);
    ack_plan_t plan_now;
    ack_plan_t plan_q;
    phase_e    phase;

    cas_resolve u_resolve (
        .m_has_win  (m_has_win),
        .m_win_line (m_win_line),
        .m_base     (m_base),
        .s_has_win  (s_has_win),
        .s_win_line (s_win_line),
        .s_base     (s_base),
        .plan       (plan_now)
    );

    cas_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .ack_req (ack_req),
        .plan_in (plan_now),
        .phase   (phase),
        .plan_q  (plan_q)
    );

    cas_drive u_drive (
        .phase      (phase),
        .plan_q     (plan_q),
        .m_ack_stb  (m_ack_stb),
        .m_ack_line (m_ack_line),
        .s_ack_stb  (s_ack_stb),
        .s_ack_line (s_ack_line),
        .vec_valid  (vec_valid),
        .vec        (vec),
        .gline      (gline)
    );
endmodule

// File: rtl/cascade_ack_seq_chk.sv
module cascade_ack_seq_chk
    import casack_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              m_ack_stb,
    input logic [LINE_W-1:0] m_ack_line,
    input logic              s_ack_stb,
    input logic [LINE_W-1:0] s_ack_line,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec,
    input logic [GLN_W-1:0]  gline
);
    // R1
    post_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!m_ack_stb && !s_ack_stb && !vec_valid));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(m_ack_stb && s_ack_stb));

    // R9
    vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);

    // R6
    casc_order_chk: assert property (@(posedge clk) disable iff (rst)
        s_ack_stb |=> (m_ack_stb && m_ack_line == CASC_LINE && vec_valid && gline[GLN_W-1]));

    // R3
    direct_result_chk: assert property (@(posedge clk) disable iff (rst)
        (m_ack_stb && !vec_valid) |=>
            (vec_valid && gline == {1'b0, $past(m_ack_line)} && vec[LINE_W-1:0] == $past(m_ack_line)));

    // R4
    vec_line_match_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec[LINE_W-1:0] == gline[LINE_W-1:0]));

    // R6
    casc_line_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && gline[GLN_W-1]) |-> (m_ack_stb && m_ack_line == CASC_LINE));
endmodule

bind cascade_ack_seq cascade_ack_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .m_ack_stb  (m_ack_stb),
    .m_ack_line (m_ack_line),
    .s_ack_stb  (s_ack_stb),
    .s_ack_line (s_ack_line),
    .vec_valid  (vec_valid),
    .vec        (vec),
    .gline      (gline)
);

// File: tb/cascade_ack_seq_tb.sv
`timescale 1ns/1ps
module cascade_ack_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ack_req = 1'b0;
    logic       m_has_win = 1'b0;
    logic [2:0] m_win_line = '0;
    logic [4:0] m_base = '0;
    logic       s_has_win = 1'b0;
    logic [2:0] s_win_line = '0;
    logic [4:0] s_base = '0;
    logic       m_ack_stb, s_ack_stb, vec_valid;
    logic [2:0] m_ack_line, s_ack_line;
    logic [7:0] vec;
    logic [3:0] gline;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cascade_ack_seq u_dut (
        .clk(clk), .rst(rst), .ack_req(ack_req),
        .m_has_win(m_has_win), .m_win_line(m_win_line), .m_base(m_base),
        .s_has_win(s_has_win), .s_win_line(s_win_line), .s_base(s_base),
        .m_ack_stb(m_ack_stb), .m_ack_line(m_ack_line),
        .s_ack_stb(s_ack_stb), .s_ack_line(s_ack_line),
        .vec_valid(vec_valid), .vec(vec), .gline(gline)
    );

    // Behavioural model: ph 0 idle, 1 strobe, 2 result; kind 0 spurious primary,
    // 1 direct, 2 cascade hit, 3 cascade miss.
    int ph = 0;
    int kind = 0;
    int lm = 0, ls = 0, mb = 0, sb = 0;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0;
        end else if (ph != 1 && ack_req) begin
            ph = 1;
            mb = m_base; sb = s_base; lm = m_win_line; ls = s_win_line;
            if (!m_has_win) kind = 0;
            else if (m_win_line != 3'd2) kind = 1;
            else if (s_has_win) kind = 2;
            else kind = 3;
        end else if (ph == 1) begin
            ph = 2;
        end else begin
            ph = 0;
        end
    end

    function automatic string tag_of();
        if (ph == 0) return "R1/R7 idle";
        case (kind)
            0: return "R2";
            1: return "R3";
            2: return (ph == 2) ? "R4/R6" : "R4";
            default: return (ph == 2) ? "R5/R6" : "R5";
        endcase
    endfunction

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag_of(), what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int e_m, e_s, e_v, e_ml, e_sl, e_vec, e_gl;
        e_m = 0; e_s = 0; e_v = 0; e_ml = 0; e_sl = 0; e_vec = 0; e_gl = 0;
        if (ph == 1) begin
            if (kind == 1) begin e_m = 1; e_ml = lm; end
            if (kind == 2) begin e_s = 1; e_sl = ls; end
        end else if (ph == 2) begin
            e_v = 1;
            if (kind >= 2) begin e_m = 1; e_ml = 2; end
            case (kind)
                0: begin e_vec = mb*8 + 7;  e_gl = 7;      end
                1: begin e_vec = mb*8 + lm; e_gl = lm;     end
                2: begin e_vec = sb*8 + ls; e_gl = 8 + ls; end
                default: begin e_vec = sb*8 + 7; e_gl = 15; end
            endcase
        end
        check("m_ack_stb", m_ack_stb, e_m);
        check("s_ack_stb", s_ack_stb, e_s);
        check("vec_valid", vec_valid, e_v);
        if (e_m) check("m_ack_line", m_ack_line, e_ml);
        if (e_s) check("s_ack_line", s_ack_line, e_sl);
        if (e_v) begin
            check("vec", vec, e_vec);
            check("gline", gline, e_gl);
        end
    endtask

    task automatic step(input bit rq, input bit mw, input int ml, input bit sw, input int sl,
                        input int mbv, input int sbv);
        @(negedge clk);
        compare();
        ack_req = rq; m_has_win = mw; m_win_line = 3'(ml);
        s_has_win = sw; s_win_line = 3'(sl); m_base = 5'(mbv); s_base = 5'(sbv);
    endtask

    task automatic idle_step();
        step(0, $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1),
             $urandom_range(0, 7), $urandom_range(0, 31), $urandom_range(0, 31));
    endtask

    initial begin
        // R1: held in reset
        repeat (3) step(1, 1, 3, 1, 4, 1, 2);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0);
        // R2 spurious primary
        step(1, 0, 4, 1, 1, 5'd9, 5'd14);
        idle_step(); idle_step(); idle_step();
        // R3 direct line 5, inputs changing afterwards (R8)
        step(1, 1, 5, 0, 0, 5'd3, 5'd20);
        idle_step(); idle_step(); idle_step();
        // R3 real line 7 on primary
        step(1, 1, 7, 1, 2, 5'd1, 5'd2);
        idle_step(); idle_step();
        // R4 cascade hit
        step(1, 1, 2, 1, 6, 5'd4, 5'd13);
        idle_step(); idle_step(); idle_step();
        // R5 cascade miss
        step(1, 1, 2, 0, 3, 5'd4, 5'd13);
        idle_step(); idle_step(); idle_step();
        // R7 request held across strobe cycle and accepted again at result
        step(1, 1, 6, 0, 0, 5'd8, 5'd16);
        step(1, 1, 1, 0, 0, 5'd8, 5'd16);
        step(1, 1, 2, 1, 0, 5'd8, 5'd16);
        step(0, 0, 0, 0, 0, 0, 0);
        idle_step(); idle_step(); idle_step();
        // randomized mix
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 2) != 0, $urandom_range(0, 5) != 0,
                 ($urandom_range(0, 2) == 0) ? 2 : $urandom_range(0, 7),
                 $urandom_range(0, 3) != 0, $urandom_range(0, 7),
                 $urandom_range(0, 31), $urandom_range(0, 31));
        end
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule